// File: doc/BRIEF.md
# Parallel-to-Serial Converter with Tristate Serializer

This block turns a parallel data word and a parallel driver-enable word into two serial streams that leave in lockstep on a fast clock. Both words are captured on the rising edge of a slower divided clock. The data stream carries the word bit by bit. The tristate stream tells the output driver, slot by slot, whether it should drive or float. A transmit path can use it to turn the pad driver on and off inside a burst without help from fabric logic.

Data can leave at single rate, one bit per fast-clock cycle, or at double rate, two bits per fast-clock cycle. The tristate word runs in one of two ways. It can give one control bit per fast-clock cycle, or it can give a single control bit that covers the whole word. Data and tristate each have their own clock enable. An enable that is low when a word is captured drops that word, and the matching serial output holds still for that period.

The divided clock must rise once every CYC fast cycles, where CYC is DATA_WIDTH at single rate and DATA_WIDTH/2 at double rate. Its rising edges must line up with fast-clock rising edges.

Top module: `p2s_tri_serializer`

## Requirements
- R1: While reset is high, serData is 0 and serTri is 1. A serTri value of 1 means the driver is off (high impedance).
- R2: At single rate, dWord bit 0 leaves first. The other bits follow in ascending index order, one per fast-clock cycle.
- R3: At double rate, each fast-clock cycle carries two slots. The even slot is on serData while clkFast is high, and the next odd slot is on serData while clkFast is low.
- R4: A word is captured on a rising edge of clkDiv. Its first slot appears after the first rising edge of clkFast that follows that capture. The word takes exactly CYC fast cycles, and the next word follows with no gap.
- R5: With TRI_WIDTH equal to CYC, tWord bit 0 is the first tristate slot and one tristate bit leaves per fast-clock cycle. At double rate, each tristate bit therefore covers two consecutive data slots.
- R6: With TRI_WIDTH equal to 1, tWord bit 0 controls serTri for every slot of its word.
- R7: If ceData is low at a capture edge, that data word is discarded. For the whole period, serData stays at the last data slot it showed. The next enabled word is sent normally.
- R8: If ceTri is low at a capture edge, that tristate word is discarded and serTri holds its last value for the period. This does not depend on ceData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFast | input | 1 | Serial (fast) clock |
| clkDiv | input | 1 | Divided clock that captures the parallel words |
| rst | input | 1 | Asynchronous reset, active high |
| ceData | input | 1 | Enable for the data word, sampled at clkDiv rising edges |
| ceTri | input | 1 | Enable for the tristate word, sampled at clkDiv rising edges |
| dWord | input | DATA_WIDTH | Parallel data; bit 0 is sent first |
| tWord | input | TRI_WIDTH | Parallel tristate control; bit 0 is the first slot; 1 = driver off |
| serData | output | 1 | Serial data |
| serTri | output | 1 | Serial tristate control; 1 = high impedance |

## Verification
One instance runs at double rate with 8 data bits and tristate per cycle. A second runs at single rate with 6 data bits and tristate per word. Each is fed a run of back-to-back words. Directed words come first: an asymmetric pattern, all-ones, a single set bit at each end, and words with the data enable low, the tristate enable low, or both low. Random words with random enables follow. The asymmetric and single-bit words show whether slot order is reversed or shifted by one. The double-rate pairs show whether the two clock phases are swapped. Tristate patterns such as 0110 show whether one control bit really covers two data slots. The enable cases show whether a dropped word leaks through, whether the output holds the right last slot, and whether data and tristate enables are kept apart.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

  typedef enum logic {
    RATE_SDR = 1'b0,
    RATE_DDR = 1'b1
  } rate_e;

  // strobes from the control unit to the datapath, one set per fast cycle
  typedef struct packed {
    logic loadData;   // move captured data word into the shifter
    logic shiftData;  // advance the data shifter by one cycle's worth
    logic runData;    // data shifter holds a live word this period
    logic loadTri;    // move captured tristate word into its shifter
    logic shiftTri;   // advance the tristate shifter by one slot
  } ser_strobe_t;

endpackage

// File: rtl/p2s_ctrl.sv
module p2s_ctrl
  import p2s_pkg::*;
#(
  parameter int CYC = 4
) (
  input  logic        clkFast,
  input  logic        clkDiv,
  input  logic        rst,
  input  logic        ceData,
  input  logic        ceTri,
  output ser_strobe_t strobe
);

  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST_SLOT = CW'(CYC - 1);

  logic          divSeen;
  logic          divEdge;
  logic          ceDataCap;
  logic          ceTriCap;
  logic          runData;
  logic          runTri;
  logic          locked;
  logic [CW-1:0] slotCnt;

  // enables are taken with the word, in the divided domain
  always_ff @(posedge clkDiv or posedge rst) begin
    if (rst) begin
      ceDataCap <= 1'b0;
      ceTriCap  <= 1'b0;
    end else begin
      ceDataCap <= ceData;
      ceTriCap  <= ceTri;
    end
  end

  // a divided clock seen high after being seen low marks a fresh word
  assign divEdge = clkDiv & ~divSeen;

  always_ff @(posedge clkFast or posedge rst) begin
    if (rst) begin
      divSeen <= 1'b1;
      runData <= 1'b0;
      runTri  <= 1'b0;
      slotCnt <= '0;
      locked  <= 1'b0;
    end else begin
      divSeen <= clkDiv;
      if (divEdge) begin
        runData <= ceDataCap;
        runTri  <= ceTriCap;
        slotCnt <= '0;
        locked  <= 1'b1;
      end else if (slotCnt != LAST_SLOT) begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.loadData  = divEdge & ceDataCap;
    strobe.shiftData = ~divEdge & runData;
    strobe.runData   = runData;
    strobe.loadTri   = divEdge & ceTriCap;
    strobe.shiftTri  = ~divEdge & runTri;
  end

  // once locked, a new word arrives exactly every CYC fast cycles
  assert_period_R4: assert property (@(posedge clkFast) disable iff (rst)
    (divEdge && locked) |-> (slotCnt == LAST_SLOT));

endmodule

// File: rtl/p2s_datapath.sv
module p2s_datapath
  import p2s_pkg::*;
#(
  parameter rate_e RATE       = RATE_DDR,
  parameter int    DATA_WIDTH = 8,
  parameter int    TRI_WIDTH  = 4
) (
  input  logic                  clkFast,
  input  logic                  clkDiv,
  input  logic                  rst,
  input  logic                  ceData,
  input  logic                  ceTri,
  input  logic [DATA_WIDTH-1:0] dWord,
  input  logic [TRI_WIDTH-1:0]  tWord,
  input  ser_strobe_t           strobe,
  output logic                  serData,
  output logic                  serTri
);

  localparam int STEP = (RATE == RATE_DDR) ? 2 : 1;

  logic [DATA_WIDTH-1:0] dHold;
  logic [TRI_WIDTH-1:0]  tHold;
  logic [DATA_WIDTH-1:0] shData;
  logic [TRI_WIDTH-1:0]  shTri;

  // parallel capture in the divided domain
  always_ff @(posedge clkDiv or posedge rst) begin
    if (rst) begin
      dHold <= '0;
      tHold <= '1;
    end else begin
      if (ceData) dHold <= dWord;
      if (ceTri)  tHold <= tWord;
    end
  end

  // data shifter: one or two slots per fast cycle
  always_ff @(posedge clkFast or posedge rst) begin
    if (rst) begin
      shData <= '0;
    end else if (strobe.loadData) begin
      shData <= dHold;
    end else if (strobe.shiftData) begin
      shData <= shData >> STEP;
    end
  end

  generate
    if (RATE == RATE_DDR) begin : g_ddrOut
      // high phase: even slot, low phase: odd slot; a stalled shifter
      // keeps showing the odd slot so the line stays still
      assign serData = (clkFast && strobe.runData) ? shData[0] : shData[1];
    end else begin : g_sdrOut
      assign serData = shData[0];
    end
  endgenerate

  // tristate shifter: one slot per fast cycle, or one bit per word
  generate
    if (TRI_WIDTH > 1) begin : g_triCycle
      always_ff @(posedge clkFast or posedge rst) begin
        if (rst) begin
          shTri <= '1;
        end else if (strobe.loadTri) begin
          shTri <= tHold;
        end else if (strobe.shiftTri) begin
          shTri <= {1'b1, shTri[TRI_WIDTH-1:1]};
        end
      end
    end else begin : g_triWord
      always_ff @(posedge clkFast or posedge rst) begin
        if (rst) begin
          shTri <= '1;
        end else if (strobe.loadTri) begin
          shTri <= tHold;
        end
      end
    end
  endgenerate

  assign serTri = shTri[0];

  assert_reset_state_R1: assert property (@(posedge clkFast)
    $past(rst) |-> (shData == '0 && shTri == '1));

  assert_load_data_R4: assert property (@(posedge clkFast) disable iff (rst)
    strobe.loadData |=> (shData == $past(dHold)));

  assert_load_tri_R5: assert property (@(posedge clkFast) disable iff (rst)
    strobe.loadTri |=> (shTri == $past(tHold)));

  assert_hold_data_R7: assert property (@(posedge clkFast) disable iff (rst)
    (!strobe.loadData && !strobe.shiftData) |=> $stable(shData));

  assert_hold_tri_R8: assert property (@(posedge clkFast) disable iff (rst)
    (!strobe.loadTri && !strobe.shiftTri) |=> $stable(shTri));

endmodule

// File: rtl/p2s_tri_serializer.sv
module p2s_tri_serializer
  import p2s_pkg::*;
#(
  parameter rate_e RATE       = RATE_DDR,
  parameter int    DATA_WIDTH = 8,
  parameter int    TRI_WIDTH  = 4
) (
  input  logic                  clkFast,
  input  logic                  clkDiv,
  input  logic                  rst,
  input  logic                  ceData,
  input  logic                  ceTri,
  input  logic [DATA_WIDTH-1:0] dWord,
  input  logic [TRI_WIDTH-1:0]  tWord,
  output logic                  serData,
  output logic                  serTri
);

  localparam int CYC = (RATE == RATE_DDR) ? DATA_WIDTH / 2 : DATA_WIDTH;

  ser_strobe_t strobe;

  p2s_ctrl #(
    .CYC(CYC)
  ) u_ctrl (
    .clkFast(clkFast),
    .clkDiv (clkDiv),
    .rst    (rst),
    .ceData (ceData),
    .ceTri  (ceTri),
    .strobe (strobe)
  );

  p2s_datapath #(
    .RATE      (RATE),
    .DATA_WIDTH(DATA_WIDTH),
    .TRI_WIDTH (TRI_WIDTH)
  ) u_datapath (
    .clkFast(clkFast),
    .clkDiv (clkDiv),
    .rst    (rst),
    .ceData (ceData),
    .ceTri  (ceTri),
    .dWord  (dWord),
    .tWord  (tWord),
    .strobe (strobe),
    .serData(serData),
    .serTri (serTri)
  );

endmodule

// File: tb/sim_p2s_tri_serializer.sv
`timescale 1ns/1ps
module sim_p2s_tri_serializer;
  import p2s_pkg::*;

  localparam int NW = 40;

  logic clkFast = 1'b0;
  logic rst = 1'b1;
  logic divA = 1'b0;
  logic divB = 1'b0;
  int   cntA = 0;
  int   cntB = 0;

  logic       ceDA, ceTA, sdA, stA;
  logic [7:0] dA;
  logic [3:0] tA;
  logic       ceDB, ceTB, sdB, stB;
  logic [5:0] dB;
  logic [0:0] tB;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [7:0] wD [NW];
  logic [3:0] wT [NW];
  logic       wCd[NW];
  logic       wCt[NW];

  always #10 clkFast = ~clkFast;  // 50 MHz

  // divided clocks: ratio 4 for the double-rate unit, 6 for single rate
  always @(posedge clkFast) begin
    cntA <= (cntA == 3) ? 0 : cntA + 1;
    divA <= (((cntA == 3) ? 0 : cntA + 1) < 2);
    cntB <= (cntB == 5) ? 0 : cntB + 1;
    divB <= (((cntB == 5) ? 0 : cntB + 1) < 3);
  end

  p2s_tri_serializer #(.RATE(RATE_DDR), .DATA_WIDTH(8), .TRI_WIDTH(4)) u0 (
    .clkFast(clkFast), .clkDiv(divA), .rst(rst), .ceData(ceDA), .ceTri(ceTA),
    .dWord(dA), .tWord(tA), .serData(sdA), .serTri(stA));

  p2s_tri_serializer #(.RATE(RATE_SDR), .DATA_WIDTH(6), .TRI_WIDTH(1)) u1 (
    .clkFast(clkFast), .clkDiv(divB), .rst(rst), .ceData(ceDB), .ceTri(ceTB),
    .dWord(dB), .tWord(tB), .serData(sdB), .serTri(stB));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // double rate: each tristate bit spans two consecutive data slots
  function automatic logic [7:0] triPairs(input logic [3:0] t);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = t[k/2];
    return r;
  endfunction

  task automatic runA();
    logic [7:0] obsD, obsT, expD, expT;
    logic lastD, lastT;
    lastD = 1'b0; lastT = 1'b1;
    dA = wD[0]; tA = wT[0]; ceDA = wCd[0]; ceTA = wCt[0];
    @(posedge divA);
    for (int n = 0; n < NW; n++) begin
      @(posedge clkFast);
      for (int j = 0; j < 4; j++) begin
        if (j > 0) @(posedge clkFast);
        #5;
        obsD[2*j] = sdA; obsT[2*j] = stA;
        @(negedge clkFast); #5;
        obsD[2*j+1] = sdA; obsT[2*j+1] = stA;
        if (j == 0 && n + 1 < NW) begin
          dA = wD[n+1]; tA = wT[n+1]; ceDA = wCd[n+1]; ceTA = wCt[n+1];
        end
      end
      if (wCd[n]) begin
        expD = wD[n]; lastD = wD[n][7];
        chk("R2 R3 R4 double-rate data order", obsD, expD);
      end else begin
        expD = {8{lastD}};
        chk("R7 data held with enable low", obsD, expD);
      end
      if (wCt[n]) begin
        expT = triPairs(wT[n]); lastT = wT[n][3];
        chk("R5 tristate per cycle", obsT, expT);
      end else begin
        expT = {8{lastT}};
        chk("R8 tristate held with enable low", obsT, expT);
      end
    end
  endtask

  task automatic runB();
    logic [7:0] obsD, obsT, expD, expT;
    logic lastD, lastT;
    lastD = 1'b0; lastT = 1'b1;
    obsD = '0; obsT = '0;
    dB = wD[0][5:0]; tB = wT[0][0]; ceDB = wCd[0]; ceTB = wCt[0];
    @(posedge divB);
    for (int n = 0; n < NW; n++) begin
      @(posedge clkFast);
      for (int i = 0; i < 6; i++) begin
        if (i > 0) @(posedge clkFast);
        #10;
        obsD[i] = sdB; obsT[i] = stB;
        if (i == 0 && n + 1 < NW) begin
          dB = wD[n+1][5:0]; tB = wT[n+1][0]; ceDB = wCd[n+1]; ceTB = wCt[n+1];
        end
      end
      if (wCd[n]) begin
        expD = {2'b00, wD[n][5:0]}; lastD = wD[n][5];
        chk("R2 R4 single-rate data order", obsD, expD);
      end else begin
        expD = {2'b00, {6{lastD}}};
        chk("R7 single-rate data held", obsD, expD);
      end
      if (wCt[n]) begin
        expT = {2'b00, {6{wT[n][0]}}}; lastT = wT[n][0];
        chk("R6 tristate per word", obsT, expT);
      end else begin
        expT = {2'b00, {6{lastT}}};
        chk("R8 single-rate tristate held", obsT, expT);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    ceDA = 0; ceTA = 0; dA = '0; tA = '0;
    ceDB = 0; ceTB = 0; dB = '0; tB = '0;
    // directed words first, then random
    wD[0] = 8'hA5; wT[0] = 4'b0110; wCd[0] = 1; wCt[0] = 1;
    wD[1] = 8'hFF; wT[1] = 4'b0000; wCd[1] = 1; wCt[1] = 1;
    wD[2] = 8'h3C; wT[2] = 4'b1111; wCd[2] = 0; wCt[2] = 1;
    wD[3] = 8'h00; wT[3] = 4'b0101; wCd[3] = 1; wCt[3] = 0;
    wD[4] = 8'h81; wT[4] = 4'b1001; wCd[4] = 0; wCt[4] = 0;
    wD[5] = 8'h01; wT[5] = 4'b1000; wCd[5] = 1; wCt[5] = 1;
    wD[6] = 8'h20; wT[6] = 4'b0001; wCd[6] = 1; wCt[6] = 1;
    for (int n = 7; n < NW; n++) begin
      wD[n]  = 8'($urandom);
      wT[n]  = 4'($urandom);
      wCd[n] = ($urandom % 4) != 0;
      wCt[n] = ($urandom % 4) != 0;
    end

    repeat (3) @(posedge clkFast);
    #5;
    chk("R1 reset data, double rate", {7'b0, sdA}, 8'h00);
    chk("R1 reset tristate, double rate", {7'b0, stA}, 8'h01);
    chk("R1 reset data, single rate", {7'b0, sdB}, 8'h00);
    chk("R1 reset tristate, single rate", {7'b0, stB}, 8'h01);
    @(negedge clkFast);
    rst = 1'b0;

    runA();
    runB();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule